// File: doc/BRIEF.md
# Bit-Band Alias Remapper

This block sits between one bus master and one slave port. Each 32-bit word of a 32 MB alias window stands for a single bit in a 1 MB bit-band region at the low end of the matching memory area. There are two windows: one for SRAM and one for peripherals. The block converts alias accesses into single-bit operations on that region. An alias read returns the addressed bit. An alias write becomes a locked read followed by a write that changes only that bit. Every other access goes through untouched. This includes direct accesses to the bit-band regions themselves.

For an alias address `A` in a window at `ALIAS`, the offset is `off = A - ALIAS`. The target byte is `REGION + off/32`. The bit within that byte is `off[4:2]`. The downstream access keeps the upstream transfer size. Its address is the target byte address with the low bits cleared to the size's alignment.

The data bus is little-endian by lane: the byte at address `a` sits on lanes `8*a[1:0]+7 .. 8*a[1:0]`. An instruction fetch into the SRAM alias window is forwarded unchanged, with no remapping. An instruction fetch into the peripheral alias window is refused with an error and never reaches the downstream port.

Top module: `bb_remap`

The controller has eight states:
- IDLE: accepts a request.
- FWD_REQ / FWD_WAIT: issue and await a passthrough access.
- RD_REQ / RD_WAIT: issue and await the bit-band read.
- WR_REQ / WR_WAIT: issue and await the write half of a read-modify-write.
- REPLY: presents the upstream response for one cycle.

The transitions are:
- IDLE goes to FWD_REQ for a passthrough, to RD_REQ for an alias data access, and to REPLY for a refused fetch.
- Each *_REQ state advances to its *_WAIT state when `dn_ready` is high.
- FWD_WAIT goes to REPLY on a response.
- RD_WAIT goes to WR_REQ on an error-free response to an alias write. It goes to REPLY on an error or for an alias read.
- WR_WAIT goes to REPLY on a response.
- REPLY goes back to IDLE.

## Requirements
- R1: An access outside both alias windows is issued downstream with identical address, write data, size (0 byte, 1 halfword, 2 word), strobe, write and fetch flags, and its read data and error are returned upstream.
- R2: A direct access to a bit-band region (SRAM region at 0x20000000, peripheral region at 0x40000000, each 1 MB) is passed through exactly like R1.
- R3: An alias data access is issued to byte `REGION + off/32`, with the address aligned to the upstream size, the same size, and a strobe covering the lanes of that aligned transfer.
- R4: An alias read returns the target bit (`off[4:2]` of the target byte) in read-data bit 0, with bits 31..1 zero.
- R5: An alias write issues a read and then a write to the same address and size. The write data equals the read data with only the target bit replaced by upstream write-data bit 0; all other write-data bits are ignored.
- R6: `dn_lock` is high from the read half of an alias write until its write half is accepted. `up_ready` is low from acceptance of a request until its response has been presented.
- R7: An error on the read half of an alias write returns an error upstream, and no write half is issued.
- R8: An error on the write half of an alias write returns an error upstream.
- R9: An instruction fetch (`up_fetch`=1) to the SRAM alias window (0x22000000, 32 MB) is passed through unremapped.
- R10: An instruction fetch to the peripheral alias window (0x42000000, 32 MB) returns an error and issues no downstream access.
- R11: After reset, `up_ready` is 1 and `dn_valid`, `dn_lock` and `up_rsp_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| up_valid | input | 1 | Upstream request valid |
| up_ready | output | 1 | Upstream request accepted when high with up_valid |
| up_addr | input | 32 | Upstream byte address |
| up_wdata | input | 32 | Upstream write data |
| up_size | input | 2 | Transfer size: 0 byte, 1 halfword, 2 word |
| up_strb | input | 4 | Upstream byte-lane strobe |
| up_write | input | 1 | 1 write, 0 read |
| up_fetch | input | 1 | 1 instruction fetch, 0 data access |
| up_rsp_valid | output | 1 | Upstream response valid (one cycle) |
| up_rdata | output | 32 | Upstream read data |
| up_rsp_err | output | 1 | Upstream error response |
| dn_valid | output | 1 | Downstream request valid |
| dn_ready | input | 1 | Downstream request accepted |
| dn_addr | output | 32 | Downstream byte address |
| dn_wdata | output | 32 | Downstream write data |
| dn_size | output | 2 | Downstream transfer size |
| dn_strb | output | 4 | Downstream byte-lane strobe |
| dn_write | output | 1 | Downstream write flag |
| dn_fetch | output | 1 | Downstream fetch flag |
| dn_lock | output | 1 | Held across a read-modify-write |
| dn_rsp_valid | input | 1 | Downstream response valid |
| dn_rdata | input | 32 | Downstream read data |
| dn_rsp_err | input | 1 | Downstream error response |

## Verification
The assertions watch the following on every cycle:
- A locked sequence always opens with a read.
- The lock survives acceptance of that read.
- The upstream side stays stalled while locked.
- An error in the read half ends the sequence with no further request.
- A stalled downstream request holds steady.
- Alias-read responses carry only bit 0.
- Refused peripheral fetches never reach downstream and always report an error.

Only the bench scenarios can show that the remapped address, strobe and merged write data are the right values for a given alias offset. The same holds for passthrough traffic being bit-identical and for stored memory contents changing in exactly one bit.

// File: rtl/bb_pkg.sv
package bb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FWD_REQ,
        ST_FWD_WAIT,
        ST_RD_REQ,
        ST_RD_WAIT,
        ST_WR_REQ,
        ST_WR_WAIT,
        ST_REPLY
    } bb_state_e;

    typedef enum logic [1:0] {
        K_PASS,
        K_BIT_RD,
        K_BIT_WR,
        K_DENY
    } bb_kind_e;

endpackage

// File: rtl/bb_decode.sv
module bb_decode
    import bb_pkg::*;
#(
    parameter logic [31:0] SRAM_BASE   = 32'h2000_0000,
    parameter logic [31:0] SRAM_ALIAS  = 32'h2200_0000,
    parameter logic [31:0] PERI_BASE   = 32'h4000_0000,
    parameter logic [31:0] PERI_ALIAS  = 32'h4200_0000,
    parameter int unsigned REGION_LOG2 = 20
) (
    input  logic [31:0] addr,
    input  logic [1:0]  size,
    input  logic [3:0]  strb,
    input  logic        write,
    input  logic        fetch,
    output bb_kind_e    kind,
    output logic [31:0] out_addr,
    output logic [3:0]  out_strb,
    output logic [4:0]  bitpos
);
    localparam int unsigned ALIAS_LOG2 = REGION_LOG2 + 5;
    localparam int unsigned NWIN       = 2;

    logic [NWIN-1:0] hit;
    logic [31:0]     tgt [NWIN];

    for (genvar g = 0; g < NWIN; g++) begin : g_win
        localparam logic [31:0] AB = (g == 0) ? SRAM_ALIAS : PERI_ALIAS;
        localparam logic [31:0] RB = (g == 0) ? SRAM_BASE  : PERI_BASE;
        assign hit[g] = (addr[31:ALIAS_LOG2] == AB[31:ALIAS_LOG2]);
        assign tgt[g] = RB + 32'(addr[ALIAS_LOG2-1:5]);
    end

    logic [31:0] sel;
    logic [31:0] aligned;
    logic [3:0]  lane_strb;

    always_comb begin
        sel = hit[1] ? tgt[1] : tgt[0];
        unique case (size)
            2'd0: begin
                aligned   = sel;
                lane_strb = 4'b0001 << sel[1:0];
            end
            2'd1: begin
                aligned   = {sel[31:1], 1'b0};
                lane_strb = sel[1] ? 4'b1100 : 4'b0011;
            end
            default: begin
                aligned   = {sel[31:2], 2'b00};
                lane_strb = 4'b1111;
            end
        endcase

        if (hit[1] && fetch)       kind = K_DENY;
        else if (hit[1])           kind = write ? K_BIT_WR : K_BIT_RD;
        else if (hit[0] && !fetch) kind = write ? K_BIT_WR : K_BIT_RD;
        else                       kind = K_PASS;

        out_addr = (kind == K_PASS) ? addr : aligned;
        out_strb = (kind == K_PASS) ? strb : lane_strb;
        bitpos   = {sel[1:0], addr[4:2]};
    end
endmodule

// File: rtl/bb_lane.sv
module bb_lane #(
    parameter int unsigned DW = 32,
    localparam int unsigned PW = $clog2(DW)
) (
    input  logic [DW-1:0] rd_data,
    input  logic [PW-1:0] bitpos,
    input  logic          new_bit,
    output logic          bit_out,
    output logic [DW-1:0] merged
);
    logic [DW-1:0] mask;

    always_comb begin
        mask    = {{(DW-1){1'b0}}, 1'b1} << bitpos;
        bit_out = |(rd_data & mask);
        merged  = (rd_data & ~mask) | (new_bit ? mask : '0);
    end
endmodule

// File: rtl/bb_remap.sv
module bb_remap
    import bb_pkg::*;
#(
    parameter logic [31:0] SRAM_BASE   = 32'h2000_0000,
    parameter logic [31:0] SRAM_ALIAS  = 32'h2200_0000,
    parameter logic [31:0] PERI_BASE   = 32'h4000_0000,
    parameter logic [31:0] PERI_ALIAS  = 32'h4200_0000,
    parameter int unsigned REGION_LOG2 = 20
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        up_valid,
    output logic        up_ready,
    input  logic [31:0] up_addr,
    input  logic [31:0] up_wdata,
    input  logic [1:0]  up_size,
    input  logic [3:0]  up_strb,
    input  logic        up_write,
    input  logic        up_fetch,
    output logic        up_rsp_valid,
    output logic [31:0] up_rdata,
    output logic        up_rsp_err,
    output logic        dn_valid,
    input  logic        dn_ready,
    output logic [31:0] dn_addr,
    output logic [31:0] dn_wdata,
    output logic [1:0]  dn_size,
    output logic [3:0]  dn_strb,
    output logic        dn_write,
    output logic        dn_fetch,
    output logic        dn_lock,
    input  logic        dn_rsp_valid,
    input  logic [31:0] dn_rdata,
    input  logic        dn_rsp_err
);
    bb_state_e   st, st_nx;
    bb_kind_e    kind_q, dec_kind;
    logic [31:0] dec_addr;
    logic [3:0]  dec_strb;
    logic [4:0]  dec_bitpos;

    logic [31:0] addr_q, wdata_q, rsp_data_q;
    logic [1:0]  size_q;
    logic [3:0]  strb_q;
    logic        write_q, fetch_q, newbit_q, rsp_err_q;
    logic [4:0]  bitpos_q;
    logic        lane_bit;
    logic [31:0] lane_merged;
    logic        accept;

    bb_decode #(
        .SRAM_BASE(SRAM_BASE), .SRAM_ALIAS(SRAM_ALIAS),
        .PERI_BASE(PERI_BASE), .PERI_ALIAS(PERI_ALIAS),
        .REGION_LOG2(REGION_LOG2)
    ) u_dec (
        .addr(up_addr), .size(up_size), .strb(up_strb),
        .write(up_write), .fetch(up_fetch),
        .kind(dec_kind), .out_addr(dec_addr), .out_strb(dec_strb),
        .bitpos(dec_bitpos)
    );

    bb_lane #(.DW(32)) u_lane (
        .rd_data(dn_rdata), .bitpos(bitpos_q), .new_bit(newbit_q),
        .bit_out(lane_bit), .merged(lane_merged)
    );

    assign accept = up_valid && (st == ST_IDLE);

    // next-state logic
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: if (up_valid) begin
                unique case (dec_kind)
                    K_DENY:  st_nx = ST_REPLY;
                    K_PASS:  st_nx = ST_FWD_REQ;
                    default: st_nx = ST_RD_REQ;
                endcase
            end
            ST_FWD_REQ:  if (dn_ready) st_nx = ST_FWD_WAIT;
            ST_FWD_WAIT: if (dn_rsp_valid) st_nx = ST_REPLY;
            ST_RD_REQ:   if (dn_ready) st_nx = ST_RD_WAIT;
            ST_RD_WAIT:  if (dn_rsp_valid)
                             st_nx = (!dn_rsp_err && kind_q == K_BIT_WR) ? ST_WR_REQ : ST_REPLY;
            ST_WR_REQ:   if (dn_ready) st_nx = ST_WR_WAIT;
            ST_WR_WAIT:  if (dn_rsp_valid) st_nx = ST_REPLY;
            ST_REPLY:    st_nx = ST_IDLE;
            default:     st_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // request capture and response data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q     <= K_PASS;
            addr_q     <= '0;
            wdata_q    <= '0;
            size_q     <= '0;
            strb_q     <= '0;
            write_q    <= 1'b0;
            fetch_q    <= 1'b0;
            newbit_q   <= 1'b0;
            bitpos_q   <= '0;
            rsp_data_q <= '0;
            rsp_err_q  <= 1'b0;
        end else begin
            if (accept) begin
                kind_q     <= dec_kind;
                addr_q     <= dec_addr;
                wdata_q    <= up_wdata;
                size_q     <= up_size;
                strb_q     <= dec_strb;
                write_q    <= up_write;
                fetch_q    <= up_fetch;
                newbit_q   <= up_wdata[0];
                bitpos_q   <= dec_bitpos;
                rsp_data_q <= '0;
                rsp_err_q  <= (dec_kind == K_DENY);
            end
            if (dn_rsp_valid) begin
                unique case (st)
                    ST_FWD_WAIT: begin
                        rsp_data_q <= dn_rdata;
                        rsp_err_q  <= dn_rsp_err;
                    end
                    ST_RD_WAIT: begin
                        rsp_err_q  <= dn_rsp_err;
                        rsp_data_q <= (kind_q == K_BIT_RD && !dn_rsp_err) ? {31'd0, lane_bit} : '0;
                        wdata_q    <= lane_merged;
                    end
                    ST_WR_WAIT: begin
                        rsp_err_q  <= dn_rsp_err;
                        rsp_data_q <= '0;
                    end
                    default: ;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        up_ready     = (st == ST_IDLE);
        up_rsp_valid = (st == ST_REPLY);
        up_rdata     = rsp_data_q;
        up_rsp_err   = rsp_err_q;
        dn_valid     = (st == ST_FWD_REQ) || (st == ST_RD_REQ) || (st == ST_WR_REQ);
        dn_addr      = addr_q;
        dn_wdata     = wdata_q;
        dn_size      = size_q;
        dn_strb      = strb_q;
        dn_write     = (st == ST_FWD_REQ) ? write_q : (st == ST_WR_REQ);
        dn_fetch     = (st == ST_FWD_REQ) && fetch_q;
        dn_lock      = (kind_q == K_BIT_WR) &&
                       ((st == ST_RD_REQ) || (st == ST_RD_WAIT) || (st == ST_WR_REQ));
    end
endmodule

// File: rtl/bb_remap_chk.sv
module bb_remap_chk #(
    parameter logic [31:0] SRAM_ALIAS  = 32'h2200_0000,
    parameter logic [31:0] PERI_ALIAS  = 32'h4200_0000,
    parameter int unsigned REGION_LOG2 = 20,
    localparam int unsigned AL = REGION_LOG2 + 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          up_valid,
    input logic          up_ready,
    input logic [31:AL]  up_tag,
    input logic          up_write,
    input logic          up_fetch,
    input logic          up_rsp_valid,
    input logic          up_rsp_err,
    input logic [31:1]   up_rdata_hi,
    input logic          dn_valid,
    input logic          dn_ready,
    input logic          dn_write,
    input logic          dn_lock,
    input logic [31:0]   dn_addr,
    input logic [1:0]    dn_size,
    input logic          dn_rsp_valid,
    input logic          dn_rsp_err
);
    logic in_sram, in_peri, rd_alias_q, deny_q;
    assign in_sram = (up_tag == SRAM_ALIAS[31:AL]);
    assign in_peri = (up_tag == PERI_ALIAS[31:AL]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_alias_q <= 1'b0;
            deny_q     <= 1'b0;
        end else if (up_valid && up_ready) begin
            rd_alias_q <= (in_sram || in_peri) && !up_fetch && !up_write;
            deny_q     <= in_peri && up_fetch;
        end else if (up_rsp_valid) begin
            rd_alias_q <= 1'b0;
            deny_q     <= 1'b0;
        end
    end

    assert_rmw_opens_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dn_lock) |-> dn_valid && !dn_write);

    assert_stall_while_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dn_lock |-> !up_ready);

    assert_lock_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dn_lock && dn_valid && dn_ready && !dn_write |=> dn_lock);

    assert_abort_on_read_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dn_lock && dn_rsp_valid && dn_rsp_err |=> !dn_valid && !dn_lock);

    assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dn_valid && !dn_ready |=> dn_valid && $stable(dn_addr) && $stable(dn_size) && $stable(dn_write));

    assert_single_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_alias_q && up_rsp_valid |-> up_rdata_hi == '0);

    assert_deny_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        deny_q |-> !dn_valid);

    assert_deny_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
        deny_q && up_rsp_valid |-> up_rsp_err);
endmodule

bind bb_remap bb_remap_chk #(
    .SRAM_ALIAS(SRAM_ALIAS), .PERI_ALIAS(PERI_ALIAS), .REGION_LOG2(REGION_LOG2)
) u_chk (
    .clk(clk), .rst_n(rst_n), .up_valid(up_valid), .up_ready(up_ready),
    .up_tag(up_addr[31:REGION_LOG2+5]), .up_write(up_write), .up_fetch(up_fetch),
    .up_rsp_valid(up_rsp_valid), .up_rsp_err(up_rsp_err), .up_rdata_hi(up_rdata[31:1]),
    .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_write(dn_write), .dn_lock(dn_lock),
    .dn_addr(dn_addr), .dn_size(dn_size), .dn_rsp_valid(dn_rsp_valid), .dn_rsp_err(dn_rsp_err)
);

// File: tb/tb_bb_remap.sv
module tb_bb_remap;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0, rst_n = 1'b0;
    logic up_valid = 0, up_write = 0, up_fetch = 0;
    logic [31:0] up_addr = 0, up_wdata = 0;
    logic [1:0] up_size = 0;
    logic [3:0] up_strb = 0;
    logic up_ready, up_rsp_valid, up_rsp_err;
    logic [31:0] up_rdata;
    logic dn_valid, dn_write, dn_fetch, dn_lock;
    logic [31:0] dn_addr, dn_wdata;
    logic [1:0] dn_size;
    logic [3:0] dn_strb;
    logic dn_ready = 1'b1, dn_rsp_valid = 1'b0, dn_rsp_err = 1'b0;
    logic [31:0] dn_rdata = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bb_remap dut (.*);

    int checks = 0, fails = 0;
    bit done = 0, busy = 0, mon_en = 0, stall_mode = 0;
    logic [31:0] err_rd = 32'hFFFF_FFFF, err_wr = 32'hFFFF_FFFF;

    logic [31:0] mem [logic [31:0]];
    logic [31:0] lq_addr[$], lq_wdata[$];
    logic [3:0]  lq_strb[$];
    logic [1:0]  lq_size[$];
    logic        lq_wr[$], lq_lock[$], lq_fe[$];

    function automatic logic [31:0] rdw(logic [31:0] a);
        logic [31:0] k = {a[31:2], 2'b00};
        if (mem.exists(k)) return mem[k];
        return {k[17:2], ~k[17:2]} ^ 32'h5A5A_3C3C;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // downstream behavioural memory
    logic pend = 0, p_err = 0;
    logic [31:0] p_data = 0;
    always @(negedge clk) begin
        if (!rst_n) begin
            dn_rsp_valid = 0; pend = 0;
        end else begin
            dn_rsp_valid = 0;
            if (pend) begin
                dn_rsp_valid = 1; dn_rdata = p_data; dn_rsp_err = p_err; pend = 0;
            end
            dn_ready = stall_mode ? ~dn_ready : 1'b1;
            if (dn_valid && dn_ready) begin
                logic [31:0] k, w;
                k = {dn_addr[31:2], 2'b00};
                lq_addr.push_back(dn_addr); lq_wdata.push_back(dn_wdata);
                lq_strb.push_back(dn_strb); lq_size.push_back(dn_size);
                lq_wr.push_back(dn_write); lq_lock.push_back(dn_lock); lq_fe.push_back(dn_fetch);
                p_err = (dn_write && k == err_wr) || (!dn_write && k == err_rd);
                p_data = 0;
                if (!p_err) begin
                    if (dn_write) begin
                        w = rdw(k);
                        for (int b = 0; b < 4; b++)
                            if (dn_strb[b]) w[8*b +: 8] = dn_wdata[8*b +: 8];
                        mem[k] = w;
                    end else p_data = rdw(k);
                end
                pend = 1;
            end
        end
    end

    // per-cycle model of upstream stall (R6)
    always @(posedge clk) begin
        #1;
        if (rst_n && mon_en && !done) begin
            if (up_ready !== !busy) chk(0, "R6 up_ready per-cycle", {31'd0, up_ready}, {31'd0, !busy});
            else checks++;
        end
    end

    task automatic clearq();
        lq_addr.delete(); lq_wdata.delete(); lq_strb.delete(); lq_size.delete();
        lq_wr.delete(); lq_lock.delete(); lq_fe.delete();
    endtask

    task automatic access(input logic [31:0] a, d, input logic [1:0] sz, input logic [3:0] sb,
                          input logic wr, fe, output logic [31:0] rd, output logic er);
        int n = 0;
        clearq();
        @(negedge clk);
        up_valid = 1; up_addr = a; up_wdata = d; up_size = sz; up_strb = sb;
        up_write = wr; up_fetch = fe;
        @(posedge clk);
        busy = 1;
        @(negedge clk);
        up_valid = 0;
        while (!up_rsp_valid && n < 200) begin @(negedge clk); n++; end
        if (n >= 200) chk(0, "timeout", 0, 1);
        rd = up_rdata; er = up_rsp_err; busy = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            done = 1; fails++; checks++;
            $display("FAIL watchdog act=%h exp=%h", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd, pre, exp;
        logic er;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(up_ready === 1'b1, "R11 up_ready", {31'd0, up_ready}, 1);
        chk(dn_valid === 1'b0 && dn_lock === 1'b0 && up_rsp_valid === 1'b0, "R11 idle outputs",
            {29'd0, dn_valid, dn_lock, up_rsp_valid}, 0);
        rst_n = 1;
        repeat (2) @(negedge clk);
        mon_en = 1;

        // R1 plain passthrough write then read
        access(32'h1000_0004, 32'hCAFE_1234, 2'd2, 4'hF, 1, 0, rd, er);
        chk(lq_addr.size() == 1, "R1 one request", lq_addr.size(), 1);
        chk(lq_addr[0] == 32'h1000_0004 && lq_wdata[0] == 32'hCAFE_1234, "R1 addr/data", lq_wdata[0], 32'hCAFE_1234);
        chk(lq_strb[0] == 4'hF && lq_wr[0] && !lq_lock[0] && lq_size[0] == 2, "R1 strb/size",
            {lq_strb[0], lq_size[0]}, {4'hF, 2'd2});
        chk(!er, "R1 err", er, 0);
        access(32'h1000_0004, 0, 2'd2, 4'hF, 0, 0, rd, er);
        chk(rd == 32'hCAFE_1234, "R1 readback", rd, 32'hCAFE_1234);

        // R2 direct region access, byte size
        access(32'h2000_0011, 0, 2'd0, 4'b0010, 0, 0, rd, er);
        chk(lq_addr[0] == 32'h2000_0011 && lq_size[0] == 0 && lq_strb[0] == 4'b0010, "R2 direct addr",
            lq_addr[0], 32'h2000_0011);
        chk(rd == rdw(32'h2000_0010), "R2 direct data", rd, rdw(32'h2000_0010));

        // R3/R4 alias read: base+0x1C -> bit 7 of byte 0, word size
        access(32'h2200_001C, 32'hFFFF_FFFF, 2'd2, 4'hF, 0, 0, rd, er);
        chk(lq_addr.size() == 1 && lq_addr[0] == 32'h2000_0000 && lq_size[0] == 2 && !lq_wr[0],
            "R3 alias read addr", lq_addr[0], 32'h2000_0000);
        exp = {31'd0, rdw(32'h2000_0000)[7]};
        chk(rd == exp, "R4 alias read bit7", rd, exp);
        // byte 0x13 bit 2, byte size
        access(32'h2200_0268, 0, 2'd0, 4'h1, 0, 0, rd, er);
        chk(lq_addr[0] == 32'h2000_0013 && lq_strb[0] == 4'b1000, "R3 byte lane", {lq_addr[0][27:0], lq_strb[0]},
            {28'h000_0013, 4'b1000});
        exp = {31'd0, rdw(32'h2000_0010)[26]};
        chk(rd == exp, "R4 alias read lane3", rd, exp);

        // R5 alias write to last SRAM byte bit 0, clear then set
        pre = rdw(32'h200F_FFFC);
        access(32'h23FF_FFE0, 32'hFFFF_FFFE, 2'd0, 4'h1, 1, 0, rd, er);
        chk(lq_addr.size() == 2, "R5 two halves", lq_addr.size(), 2);
        chk(lq_addr[0] == 32'h200F_FFFF && !lq_wr[0] && lq_addr[1] == 32'h200F_FFFF && lq_wr[1],
            "R3 last byte addr", lq_addr[1], 32'h200F_FFFF);
        chk(lq_strb[1] == 4'b1000 && lq_size[1] == 0, "R3 rmw strobe", lq_strb[1], 4'b1000);
        exp = pre & ~(32'd1 << 24);
        chk(lq_wdata[1] == exp, "R5 clear bit", lq_wdata[1], exp);
        chk(lq_lock[0] && lq_lock[1], "R6 lock both halves", {lq_lock[0], lq_lock[1]}, 2'b11);
        access(32'h23FF_FFE0, 32'h0000_0001, 2'd0, 4'h1, 1, 0, rd, er);
        exp = pre | (32'd1 << 24);
        chk(rdw(32'h200F_FFFC) == exp && !er, "R5 set bit stored", rdw(32'h200F_FFFC), exp);

        // R5 peripheral halfword: byte 0x403 bit 5
        pre = rdw(32'h4000_0400);
        access(32'h4200_8074, 32'h0000_0001, 2'd1, 4'h3, 1, 0, rd, er);
        chk(lq_addr.size() == 2 && lq_addr[1] == 32'h4000_0402 && lq_strb[1] == 4'b1100 && lq_size[1] == 1,
            "R3 periph halfword", lq_addr[1], 32'h4000_0402);
        exp = pre | (32'd1 << 29);
        chk(lq_wdata[1] == exp, "R5 periph merge", lq_wdata[1], exp);
        access(32'h4000_0400, 0, 2'd2, 4'hF, 0, 0, rd, er);
        chk(rd == exp, "R2 periph direct read", rd, exp);

        // R6 with downstream stalls: byte 0x105 bit 6, word size, clear
        stall_mode = 1;
        pre = rdw(32'h2000_0104);
        access(32'h2200_20B8, 32'hFFFF_FFFE, 2'd2, 4'hF, 1, 0, rd, er);
        exp = pre & ~(32'd1 << 14);
        chk(lq_addr.size() == 2 && lq_addr[1] == 32'h2000_0104 && lq_wdata[1] == exp, "R5 stalled rmw",
            lq_wdata[1], exp);
        access(32'h2200_20B8, 0, 2'd2, 4'hF, 0, 0, rd, er);
        chk(rd == 0, "R4 cleared bit reads 0", rd, 0);
        stall_mode = 0;

        // R7 read-half error
        err_rd = 32'h2000_0104;
        pre = rdw(32'h2000_0104);
        access(32'h2200_20B8, 32'h1, 2'd2, 4'hF, 1, 0, rd, er);
        chk(er, "R7 error returned", er, 1);
        chk(lq_addr.size() == 1, "R7 no write half", lq_addr.size(), 1);
        chk(rdw(32'h2000_0104) == pre, "R7 memory untouched", rdw(32'h2000_0104), pre);
        err_rd = 32'hFFFF_FFFF;

        // R8 write-half error
        err_wr = 32'h2000_0104;
        access(32'h2200_20B8, 32'h1, 2'd2, 4'hF, 1, 0, rd, er);
        chk(er && lq_addr.size() == 2, "R8 write error", {lq_addr.size(), er}, {32'd2, 1'b1});
        err_wr = 32'hFFFF_FFFF;

        // R9 SRAM alias fetch passes through
        access(32'h2200_0040, 0, 2'd2, 4'hF, 0, 1, rd, er);
        chk(lq_addr.size() == 1 && lq_addr[0] == 32'h2200_0040 && lq_fe[0] && !er, "R9 fetch passthrough",
            lq_addr[0], 32'h2200_0040);

        // R10 peripheral alias fetch refused
        access(32'h4200_0010, 0, 2'd2, 4'hF, 0, 1, rd, er);
        chk(er, "R10 fetch error", er, 1);
        chk(lq_addr.size() == 0, "R10 no downstream", lq_addr.size(), 0);

        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule